// File: doc/BRIEF.md
# Register Auto-Modify Fault Logger

This block keeps a 16-bit log of the general-register increments and decrements that the current instruction has made. After a memory fault, an operating system reads the log and undoes the partial side effects of the addressing modes. The CPU reports each auto-modification as one strobe that carries a register number and a small signed delta. The block packs up to two such records into the two bytes of the log. A one-bit-per-slot counter decides which byte a record goes to. Two changes to the same register therefore fill two separate bytes and are never added together.

A companion 16-bit status register sits next to the log and software writes it. While its top bit is set, the log is frozen. In that state both further updates and the instruction-start clear are ignored, so the contents that describe the faulting instruction survive until software clears the bit. A single read port returns either register, chosen by a select input.

Top module: `amod_log`

## Requirements
- R1: After reset the log, the companion status register and the record counter are all zero.
- R2: A record is one byte. Bits [7:3] hold the delta as a 5-bit two's-complement value sign-extended from the 3-bit input, and bits [2:0] hold the register number.
- R3: The first accepted update of an instruction is written to bits [7:0] and the second to bits [15:8]. The other byte keeps its value.
- R4: Two updates to the same register stay separate records and are not summed: two +2 updates of register 7 read back as 16'o013427.
- R5: Once two records are held, any further update within the same instruction leaves the log unchanged.
- R6: When not frozen, an instruction-start pulse clears the log and the counter. An update in the same cycle is accepted as the first record and lands in bits [7:0].
- R7: A software write loads the companion register on the next edge. While its bit 15 is set (for example after a write of 16'o100000), updates and instruction-start pulses leave the log unchanged. Writes to the companion register are still accepted in that state.
- R8: With rd_sel = 1 the read data is the log; with rd_sel = 0 it is the companion register. The read data follows rd_sel in the same cycle.
- R9: Input deltas -2, -1, +1 and +2 (3'b110, 3'b111, 3'b001, 3'b010) are stored as 5'b11110, 5'b11111, 5'b00001 and 5'b00010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_start | input | 1 | Pulse at the start of each instruction |
| upd_valid | input | 1 | An auto-modify record is presented this cycle |
| upd_reg | input | 3 | General-register number of the update |
| upd_delta | input | 3 | Signed delta of the update |
| sr_wr_en | input | 1 | Software write strobe for the companion register |
| sr_wr_data | input | 16 | Software write data for the companion register |
| rd_sel | input | 1 | Read select: 1 log, 0 companion register |
| rd_data | output | 16 | Read data |

## Verification
The bench sweeps every pair of register numbers and legal deltas. It enters the first record both with the instruction-start pulse and one cycle after it, and it always offers a third update. A design that merged same-register deltas would fail the diagonal of that sweep. A design that steered by register equality would do the same, and one that let the third record through would overwrite the upper byte. The bench also sets the freeze bit and then sends updates and starts. A design that still cleared on instruction start would lose the logged values. A final step checks that the log resumes only after the freeze bit is cleared and a new start arrives.

// File: rtl/amod_pkg.sv
package amod_pkg;
    typedef enum logic {
        RD_STATUS = 1'b0,
        RD_LOG    = 1'b1
    } rd_src_e;
endpackage

// File: rtl/amod_rec_pack.sv
module amod_rec_pack #(
    parameter int REG_W = 3,
    parameter int IN_DW = 3,
    parameter int FLD_W = 5
) (
    input  logic [REG_W-1:0]       reg_no,
    input  logic [IN_DW-1:0]       delta,
    output logic [FLD_W+REG_W-1:0] rec
);
    generate
        if (FLD_W > IN_DW) begin : g_ext
            assign rec = {{(FLD_W-IN_DW){delta[IN_DW-1]}}, delta, reg_no};
        end else begin : g_same
            assign rec = {delta[FLD_W-1:0], reg_no};
        end
    endgenerate
endmodule

// File: rtl/amod_slot_ctl.sv
module amod_slot_ctl #(
    parameter int NREC = 2,
    parameter int CW   = $clog2(NREC + 1)
) (
    input  logic            frozen,
    input  logic            start,
    input  logic            valid,
    input  logic [CW-1:0]   cnt_q,
    output logic [NREC-1:0] slot,
    output logic            clear,
    output logic [CW-1:0]   cnt_d
);
    logic [CW-1:0] base;
    logic          accept;

    always_comb begin
        clear  = start && !frozen;
        base   = clear ? '0 : cnt_q;
        accept = valid && !frozen && (base < CW'(NREC));
        slot   = accept ? (NREC'(1) << base) : '0;
        cnt_d  = frozen ? cnt_q : base + CW'(accept);
    end
endmodule

// File: rtl/amod_rd_mux.sv
module amod_rd_mux #(
    parameter int W = 16
) (
    input  logic         sel,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] log_v,
    output logic [W-1:0] dout
);
    import amod_pkg::*;
    rd_src_e src;

    always_comb begin
        src = rd_src_e'(sel);
        case (src)
            RD_LOG:  dout = log_v;
            default: dout = stat;
        endcase
    end
endmodule

// File: rtl/amod_log.sv
module amod_log #(
    parameter int NREC    = 2,
    parameter int REG_W   = 3,
    parameter int IN_DW   = 3,
    parameter int FLD_W   = 5,
    parameter int SR_W    = 16,
    parameter int FRZ_BIT = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          instr_start,
    input  logic                          upd_valid,
    input  logic [REG_W-1:0]              upd_reg,
    input  logic [IN_DW-1:0]              upd_delta,
    input  logic                          sr_wr_en,
    input  logic [SR_W-1:0]               sr_wr_data,
    input  logic                          rd_sel,
    output logic [NREC*(FLD_W+REG_W)-1:0] rd_data
);
    localparam int RW    = FLD_W + REG_W;
    localparam int LOG_W = NREC * RW;
    localparam int CW    = $clog2(NREC + 1);

    typedef struct packed {
        logic [SR_W-1:0]  stat;
        logic [LOG_W-1:0] log_v;
        logic [CW-1:0]    cnt;
    } state_t;

    state_t st_d, st_q;

    logic [RW-1:0]    rec;
    logic [NREC-1:0]  slot;
    logic             clear;
    logic [CW-1:0]    cnt_d;
    logic             frozen;
    logic [LOG_W-1:0] log_q;
    logic [SR_W-1:0]  stat_q;
    logic [CW-1:0]    cnt_q;

    assign log_q  = st_q.log_v;
    assign stat_q = st_q.stat;
    assign cnt_q  = st_q.cnt;
    assign frozen = st_q.stat[FRZ_BIT];

    amod_rec_pack #(.REG_W(REG_W), .IN_DW(IN_DW), .FLD_W(FLD_W)) i_pack (
        .reg_no (upd_reg),
        .delta  (upd_delta),
        .rec    (rec)
    );

    amod_slot_ctl #(.NREC(NREC), .CW(CW)) i_slot (
        .frozen (frozen),
        .start  (instr_start),
        .valid  (upd_valid),
        .cnt_q  (cnt_q),
        .slot   (slot),
        .clear  (clear),
        .cnt_d  (cnt_d)
    );

    always_comb begin
        st_d = st_q;
        if (sr_wr_en) begin
            st_d.stat = sr_wr_data;
        end
        if (clear) begin
            st_d.log_v = '0;
        end
        for (int i = 0; i < NREC; i++) begin
            if (slot[i]) begin
                st_d.log_v[i*RW +: RW] = rec;
            end
        end
        st_d.cnt = cnt_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    amod_rd_mux #(.W(LOG_W)) i_rd (
        .sel   (rd_sel),
        .stat  (stat_q[LOG_W-1:0]),
        .log_v (log_q),
        .dout  (rd_data)
    );
endmodule

// File: rtl/amod_log_chk.sv
module amod_log_chk #(
    parameter int LOG_W   = 16,
    parameter int RW      = 8,
    parameter int CW      = 2,
    parameter int NREC    = 2,
    parameter int SR_W    = 16,
    parameter int FRZ_BIT = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_start,
    input logic             upd_valid,
    input logic             rd_sel,
    input logic [LOG_W-1:0] rd_data,
    input logic [LOG_W-1:0] log_q,
    input logic [SR_W-1:0]  stat_q,
    input logic [CW-1:0]    cnt_q
);
    logic frz;
    assign frz = stat_q[FRZ_BIT];

    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frz |=> $stable(log_q));

    assert_start_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && instr_start && !upd_valid) |=> (log_q == '0 && cnt_q == '0));

    assert_first_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && upd_valid && !instr_start && cnt_q == '0)
        |=> (cnt_q == CW'(1) && log_q[LOG_W-1:RW] == $past(log_q[LOG_W-1:RW])));

    assert_full_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_start && cnt_q == CW'(NREC)) |=> $stable(log_q));

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(NREC));

    assert_read_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == (rd_sel ? log_q : stat_q[LOG_W-1:0]));
endmodule

bind amod_log amod_log_chk #(
    .LOG_W(LOG_W), .RW(RW), .CW(CW), .NREC(NREC), .SR_W(SR_W), .FRZ_BIT(FRZ_BIT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_start (instr_start),
    .upd_valid   (upd_valid),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .log_q       (log_q),
    .stat_q      (stat_q),
    .cnt_q       (cnt_q)
);

// File: tb/test_amod_log.sv
`timescale 1ns/1ps
module test_amod_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_start = 1'b0;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_reg = '0;
    logic [2:0]  upd_delta = '0;
    logic        sr_wr_en = 1'b0;
    logic [15:0] sr_wr_data = '0;
    logic        rd_sel = 1'b1;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    amod_log i_amod_log (
        .clk(clk), .rst_n(rst_n), .instr_start(instr_start),
        .upd_valid(upd_valid), .upd_reg(upd_reg), .upd_delta(upd_delta),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%o expected=%o", req, got, exp);
        end
    endtask

    function automatic logic [7:0] rec_of(input int r, input int d);
        return 8'(((d & 31) << 3) | (r & 7));
    endfunction

    task automatic cyc(input logic st, input logic v, input int r, input int d);
        instr_start = st;
        upd_valid   = v;
        upd_reg     = 3'(r);
        upd_delta   = 3'(d);
        @(negedge clk);
        instr_start = 1'b0;
        upd_valid   = 1'b0;
    endtask

    task automatic read(input logic sel, output logic [15:0] v);
        rd_sel = sel;
        #0.5;
        v = rd_data;
    endtask

    task automatic sr_write(input logic [15:0] v);
        sr_wr_en   = 1'b1;
        sr_wr_data = v;
        @(negedge clk);
        sr_wr_en   = 1'b0;
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int dv[4];
        logic [15:0] v;
        dv = '{-2, -1, 1, 2};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read(1'b1, v); check("R1 log", v, 16'h0000);
        read(1'b0, v); check("R1 status", v, 16'h0000);

        // R9 encodings, each as first record after a start
        for (int k = 0; k < 4; k++) begin
            cyc(1'b1, 1'b1, 5, dv[k]);
            read(1'b1, v);
            case (k)
                0: check("R9 -2", {8'h00, v[7:0]}, {8'h00, 5'b11110, 3'd5});
                1: check("R9 -1", {8'h00, v[7:0]}, {8'h00, 5'b11111, 3'd5});
                2: check("R9 +1", {8'h00, v[7:0]}, {8'h00, 5'b00001, 3'd5});
                default: check("R9 +2", {8'h00, v[7:0]}, {8'h00, 5'b00010, 3'd5});
            endcase
        end

        // R4 same register twice
        cyc(1'b1, 1'b0, 0, 0);
        read(1'b1, v); check("R6 clear", v, 16'h0000);
        cyc(1'b0, 1'b1, 7, 2);
        read(1'b1, v); check("R3 first low", v, 16'h0017);
        cyc(1'b0, 1'b1, 7, 2);
        read(1'b1, v); check("R4 no sum", v, 16'o013427);

        // Sweep: R2 R3 R5 R6
        for (int r1 = 0; r1 < 8; r1++)
        for (int i1 = 0; i1 < 4; i1++)
        for (int r2 = 0; r2 < 8; r2++)
        for (int i2 = 0; i2 < 4; i2++) begin
            if (((r1 + i1 + r2 + i2) & 1) == 0) begin
                cyc(1'b1, 1'b1, r1, dv[i1]);
            end else begin
                cyc(1'b1, 1'b0, 0, 0);
                cyc(1'b0, 1'b1, r1, dv[i1]);
            end
            cyc(1'b0, 1'b1, r2, dv[i2]);
            cyc(1'b0, 1'b1, r1 ^ 3, dv[3 - i1]);
            read(1'b1, v);
            check("R2/R3/R5 sweep", v, {rec_of(r2, dv[i2]), rec_of(r1, dv[i1])});
        end

        // R7 freeze
        cyc(1'b1, 1'b1, 3, -1);
        cyc(1'b0, 1'b1, 4, 1);
        sr_write(16'o100000);
        read(1'b0, v); check("R8 status read", v, 16'o100000);
        cyc(1'b1, 1'b1, 6, 2);
        read(1'b1, v); check("R7 frozen start", v, {rec_of(4, 1), rec_of(3, -1)});
        cyc(1'b1, 1'b0, 0, 0);
        cyc(1'b0, 1'b1, 1, -2);
        read(1'b1, v); check("R7 frozen update", v, {rec_of(4, 1), rec_of(3, -1)});
        sr_write(16'o000123);
        read(1'b0, v); check("R7 write while frozen", v, 16'o000123);
        cyc(1'b0, 1'b1, 2, 2);
        read(1'b1, v); check("R5 still full", v, {rec_of(4, 1), rec_of(3, -1)});
        cyc(1'b1, 1'b1, 2, 2);
        read(1'b1, v); check("R6 resume", v, {8'h00, rec_of(2, 2)});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule